// File: doc/BRIEF.md
# Multi-cycle 8-bit accumulator processor core

This block is a small multi-cycle processor. All arithmetic passes through one 8-bit accumulator. Two general registers, B and C, supply the second operand. A 16-bit program counter and a 16-bit stack pointer form addresses on a single byte-wide memory port. Every instruction starts with a fetch of one byte. That byte is decoded, and the instruction then spends one state on each further operand byte or stack access before it completes. Each completed instruction is marked by a one-cycle `instr_done` pulse.

The stack grows upward from a base address set by a parameter. A subroutine call saves the 16-bit return address as two bytes, and a return rebuilds that address by stepping the stack pointer back twice. The contents of the architectural registers appear on debug outputs, so a surrounding system or a bench can follow execution.

Memory reads have a latency of one cycle. The byte requested while `mem_rd` is high must be on `mem_rdata` during the following cycle. Writes take effect at the clock edge on which `mem_wr` is high.

Top module: `cpu8_core`

## Requirements
- R1: While reset is low, PC reads 0x0000, SP reads the STACK_BASE parameter (default 0x0300), and the accumulator, B, C, the zero flag and `instr_done` all read 0.
- R2: Each instruction is fetched from address PC, and PC then steps by one. Bits [5:0] of the byte are the opcode: 00 NOP, 01 JMP, 02 JZ, 03 JNZ, 04 CALL, 05 RET, 06 PUSH, 07 POP, 08 LDI, 09 STR, 0A LDR, 0B ADD, 0C SUB, 0D MUL, 0E DIV, 0F SHL, 10 SHR, 11 AND, 12 OR, 13 INC, 14 CLZ, 15 CLR.
- R3: Bits [7:6] of the byte form a register field. A value of 0 selects B and any other value selects C. The field picks the second operand of LDR, ADD, SUB, MUL, DIV, SHL, SHR, AND and OR, and it picks the destination of STR, which copies the accumulator. LDR copies the selected register into the accumulator.
- R4: ADD, SUB, MUL, AND, OR and INC (which adds 1) keep the low 8 bits of the result. After each of these, and after DIV, SHL and SHR, the zero flag is set exactly when the new accumulator value is 0.
- R5: DIV places the integer quotient in the accumulator. A zero divisor leaves the accumulator unchanged.
- R6: SHL and SHR shift the accumulator by the register value. Any shift amount of 8 or more gives 0.
- R7: CLZ clears the accumulator and sets the zero flag. CLR clears the accumulator and leaves the zero flag unchanged. LDI, LDR, STR and POP leave the zero flag unchanged.
- R8: JMP, JZ and JNZ are each followed by two target bytes, high byte first. JMP always loads PC with the target. JZ does so only when the zero flag is 1, and JNZ only when it is 0. A jump that is not taken continues at the byte after the operands.
- R9: CALL reads a two-byte target, high byte first. It writes the low byte of the return address at SP and the high byte at SP+1, leaves SP two higher, and jumps to the target.
- R10: RET decrements SP and reads the high byte, then decrements SP again and reads the low byte. It resumes at the 16-bit address those two bytes form.
- R11: PUSH writes the accumulator at SP and then increments SP. POP decrements SP and then loads the byte found there into the accumulator. LDI loads the byte that follows the opcode.
- R12: An opcode outside the list in R2 behaves as NOP and changes only PC.
- R13: `mem_rd` and `mem_wr` are never high in the same cycle. `instr_done` is a single-cycle pulse, one per instruction. A NOP occupies 3 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Read request; data is expected in the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data for the previous cycle's request |
| instr_done | output | 1 | One-cycle pulse after each instruction completes |
| dbg_pc | output | 16 | Program counter |
| dbg_sp | output | 16 | Stack pointer |
| dbg_acc | output | 8 | Accumulator |
| dbg_b | output | 8 | Register B |
| dbg_c | output | 8 | Register C |
| dbg_zero | output | 1 | Zero flag |

## Verification
The assertions rely on memory that returns, one cycle later, the byte at the address requested with `mem_rd`, and on a reset that is held low across at least one clock edge. The bench's memory model follows exactly that one-cycle timing. Each program is loaded while reset is held and is started at address 0. Every program stays inside the model's 1 KiB and keeps its code clear of the stack region at 0x0300, so no push or call overwrites an instruction that is still to run.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

    localparam int DW = 8;
    localparam int AW = 16;

    typedef enum logic [5:0] {
        OPC_NOP = 6'h00, OPC_JMP = 6'h01, OPC_JZ  = 6'h02, OPC_JNZ = 6'h03,
        OPC_CALL = 6'h04, OPC_RET = 6'h05, OPC_PUSH = 6'h06, OPC_POP = 6'h07,
        OPC_LDI = 6'h08, OPC_STR = 6'h09, OPC_LDR = 6'h0A, OPC_ADD = 6'h0B,
        OPC_SUB = 6'h0C, OPC_MUL = 6'h0D, OPC_DIV = 6'h0E, OPC_SHL = 6'h0F,
        OPC_SHR = 6'h10, OPC_AND = 6'h11, OPC_OR  = 6'h12, OPC_INC = 6'h13,
        OPC_CLZ = 6'h14, OPC_CLR = 6'h15
    } opcode_e;

    typedef enum logic [3:0] {
        K_NOP, K_JMP, K_JZ, K_JNZ, K_CALL, K_RET, K_PUSH, K_POP,
        K_LDI, K_STR, K_ALU, K_CLZ, K_CLR
    } kind_e;

    typedef enum logic [3:0] {
        A_MOV, A_ADD, A_SUB, A_MUL, A_DIV, A_SHL, A_SHR, A_AND, A_OR, A_INC
    } alu_e;

    typedef struct packed {
        kind_e kind;
        alu_e  op;
        logic  sel_c;
    } dec_t;

    typedef enum logic [3:0] {
        S_FETCH, S_DECODE, S_OPHI, S_OPLO, S_EXEC, S_IMM,
        S_CALLLO, S_CALLHI, S_RETHI, S_RETLO, S_POPRD
    } state_e;

endpackage

// File: rtl/cpu8_decode.sv
module cpu8_decode
    import cpu8_pkg::*;
(
    input  logic [DW-1:0] instr,
    output dec_t          dec
);

    always_comb begin
        dec.kind  = K_NOP;
        dec.op    = A_MOV;
        dec.sel_c = |instr[DW-1:DW-2];
        case (instr[5:0])
            OPC_JMP:  dec.kind = K_JMP;
            OPC_JZ:   dec.kind = K_JZ;
            OPC_JNZ:  dec.kind = K_JNZ;
            OPC_CALL: dec.kind = K_CALL;
            OPC_RET:  dec.kind = K_RET;
            OPC_PUSH: dec.kind = K_PUSH;
            OPC_POP:  dec.kind = K_POP;
            OPC_LDI:  dec.kind = K_LDI;
            OPC_STR:  dec.kind = K_STR;
            OPC_CLZ:  dec.kind = K_CLZ;
            OPC_CLR:  dec.kind = K_CLR;
            OPC_LDR:  begin dec.kind = K_ALU; dec.op = A_MOV; end
            OPC_ADD:  begin dec.kind = K_ALU; dec.op = A_ADD; end
            OPC_SUB:  begin dec.kind = K_ALU; dec.op = A_SUB; end
            OPC_MUL:  begin dec.kind = K_ALU; dec.op = A_MUL; end
            OPC_DIV:  begin dec.kind = K_ALU; dec.op = A_DIV; end
            OPC_SHL:  begin dec.kind = K_ALU; dec.op = A_SHL; end
            OPC_SHR:  begin dec.kind = K_ALU; dec.op = A_SHR; end
            OPC_AND:  begin dec.kind = K_ALU; dec.op = A_AND; end
            OPC_OR:   begin dec.kind = K_ALU; dec.op = A_OR;  end
            OPC_INC:  begin dec.kind = K_ALU; dec.op = A_INC; end
            default:  dec.kind = K_NOP;
        endcase
    end

endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
    import cpu8_pkg::*;
#(
    parameter int W = DW
) (
    input  alu_e         op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    localparam int           SH_W  = $clog2(W);
    localparam logic [W-1:0] SH_LIM = W[W-1:0];

    logic [2*W-1:0] prod;

    always_comb begin
        prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        case (op)
            A_MOV:   y = b;
            A_ADD:   y = a + b;
            A_SUB:   y = a - b;
            A_MUL:   y = prod[W-1:0];
            A_DIV:   y = (b == '0) ? a : a / b;
            A_SHL:   y = (b >= SH_LIM) ? '0 : a << b[SH_W-1:0];
            A_SHR:   y = (b >= SH_LIM) ? '0 : a >> b[SH_W-1:0];
            A_AND:   y = a & b;
            A_OR:    y = a | b;
            A_INC:   y = a + W'(1);
            default: y = a;
        endcase
    end

    always_comb begin
        if (op == A_DIV && b == '0)
            AST_DIV0_KEEP: assert (y == a) else $error("divide by zero altered operand"); // R5
        if ((op == A_SHL || op == A_SHR) && b >= SH_LIM)
            AST_WIDE_SHIFT: assert (y == '0) else $error("wide shift not zero"); // R6
    end

endmodule

// File: rtl/cpu8_seq.sv
module cpu8_seq
    import cpu8_pkg::*;
#(
    parameter logic [AW-1:0] STACK_BASE = 16'h0300
) (
    input  logic          clk,
    input  logic          rst_n,
    input  dec_t          dec,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output alu_e          alu_op,
    output logic [DW-1:0] alu_a,
    output logic [DW-1:0] alu_b,
    input  logic [DW-1:0] alu_y,
    output logic          instr_done,
    output logic [AW-1:0] dbg_pc,
    output logic [AW-1:0] dbg_sp,
    output logic [DW-1:0] dbg_acc,
    output logic [DW-1:0] dbg_b,
    output logic [DW-1:0] dbg_c,
    output logic          dbg_zero
);

    localparam int HB = DW;

    typedef struct packed {
        state_e        st;
        logic [AW-1:0] pc;
        logic [AW-1:0] sp;
        logic [AW-1:0] ar;
        logic [DW-1:0] tr;
        logic [DW-1:0] acc;
        logic [DW-1:0] rb;
        logic [DW-1:0] rc;
        logic          zf;
        logic          done;
        dec_t          dec;
    } regs_t;

    regs_t q_q, q_d;

    assign alu_op = q_q.dec.op;
    assign alu_a  = q_q.acc;
    assign alu_b  = q_q.dec.sel_c ? q_q.rc : q_q.rb;

    always_comb begin
        q_d       = q_q;
        q_d.done  = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = q_q.pc;
        mem_wdata = q_q.acc;
        case (q_q.st)
            S_FETCH: begin
                mem_rd  = 1'b1;
                q_d.ar  = q_q.pc;
                q_d.pc  = q_q.pc + AW'(1);
                q_d.st  = S_DECODE;
            end
            S_DECODE: begin
                q_d.dec = dec;
                case (dec.kind)
                    K_JMP, K_JZ, K_JNZ, K_CALL, K_LDI: begin
                        mem_rd = 1'b1;
                        q_d.pc = q_q.pc + AW'(1);
                        q_d.st = (dec.kind == K_LDI) ? S_IMM : S_OPHI;
                    end
                    K_RET, K_POP: begin
                        mem_rd   = 1'b1;
                        mem_addr = q_q.sp - AW'(1);
                        q_d.sp   = q_q.sp - AW'(1);
                        q_d.st   = (dec.kind == K_RET) ? S_RETHI : S_POPRD;
                    end
                    default: q_d.st = S_EXEC;
                endcase
            end
            S_OPHI: begin
                q_d.tr = mem_rdata;
                mem_rd = 1'b1;
                q_d.pc = q_q.pc + AW'(1);
                q_d.st = S_OPLO;
            end
            S_OPLO: begin
                q_d.ar = {q_q.tr, mem_rdata};
                q_d.st = (q_q.dec.kind == K_CALL) ? S_CALLLO : S_EXEC;
            end
            S_CALLLO: begin
                mem_wr    = 1'b1;
                mem_addr  = q_q.sp;
                mem_wdata = q_q.pc[HB-1:0];
                q_d.sp    = q_q.sp + AW'(1);
                q_d.st    = S_CALLHI;
            end
            S_CALLHI: begin
                mem_wr    = 1'b1;
                mem_addr  = q_q.sp;
                mem_wdata = q_q.pc[AW-1:HB];
                q_d.sp    = q_q.sp + AW'(1);
                q_d.pc    = q_q.ar;
                q_d.done  = 1'b1;
                q_d.st    = S_FETCH;
            end
            S_RETHI: begin
                q_d.tr   = mem_rdata;
                mem_rd   = 1'b1;
                mem_addr = q_q.sp - AW'(1);
                q_d.sp   = q_q.sp - AW'(1);
                q_d.st   = S_RETLO;
            end
            S_RETLO: begin
                q_d.pc   = {q_q.tr, mem_rdata};
                q_d.done = 1'b1;
                q_d.st   = S_FETCH;
            end
            S_POPRD, S_IMM: begin
                q_d.acc  = mem_rdata;
                q_d.done = 1'b1;
                q_d.st   = S_FETCH;
            end
            S_EXEC: begin
                q_d.done = 1'b1;
                q_d.st   = S_FETCH;
                case (q_q.dec.kind)
                    K_JMP: q_d.pc = q_q.ar;
                    K_JZ:  if (q_q.zf)  q_d.pc = q_q.ar;
                    K_JNZ: if (!q_q.zf) q_d.pc = q_q.ar;
                    K_PUSH: begin
                        mem_wr   = 1'b1;
                        mem_addr = q_q.sp;
                        q_d.sp   = q_q.sp + AW'(1);
                    end
                    K_STR: begin
                        if (q_q.dec.sel_c) q_d.rc = q_q.acc;
                        else               q_d.rb = q_q.acc;
                    end
                    K_ALU: begin
                        q_d.acc = alu_y;
                        if (q_q.dec.op != A_MOV) q_d.zf = (alu_y == '0);
                    end
                    K_CLZ: begin
                        q_d.acc = '0;
                        q_d.zf  = 1'b1;
                    end
                    K_CLR: q_d.acc = '0;
                    default: ;
                endcase
            end
            default: q_d.st = S_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q.st   <= S_FETCH;
            q_q.pc   <= '0;
            q_q.sp   <= STACK_BASE;
            q_q.ar   <= '0;
            q_q.tr   <= '0;
            q_q.acc  <= '0;
            q_q.rb   <= '0;
            q_q.rc   <= '0;
            q_q.zf   <= 1'b0;
            q_q.done <= 1'b0;
            q_q.dec  <= '{kind: K_NOP, op: A_MOV, sel_c: 1'b0};
        end else begin
            q_q <= q_d;
        end
    end

    assign instr_done = q_q.done;
    assign dbg_pc     = q_q.pc;
    assign dbg_sp     = q_q.sp;
    assign dbg_acc    = q_q.acc;
    assign dbg_b      = q_q.rb;
    assign dbg_c      = q_q.rc;
    assign dbg_zero   = q_q.zf;

    AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)) else $error("read and write together"); // R13
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> !instr_done) else $error("done wider than one cycle"); // R13
    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> (dbg_pc == $past(dbg_pc) + AW'(1))) else $error("fetch did not advance PC"); // R2
    AST_WRITE_BUMPS_SP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (dbg_sp == $past(dbg_sp) + AW'(1))) else $error("stack write without SP step"); // R11
    AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && q_q.dec.kind == K_ALU && q_q.dec.op != A_MOV)
            |-> (dbg_zero == (dbg_acc == '0))) else $error("zero flag stale"); // R4
    AST_CLZ_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && q_q.dec.kind == K_CLZ) |-> (dbg_zero && dbg_acc == '0)) else $error("CLZ result"); // R7

endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
    import cpu8_pkg::*;
#(
    parameter logic [15:0] STACK_BASE = 16'h0300
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] mem_addr,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic        instr_done,
    output logic [15:0] dbg_pc,
    output logic [15:0] dbg_sp,
    output logic [7:0]  dbg_acc,
    output logic [7:0]  dbg_b,
    output logic [7:0]  dbg_c,
    output logic        dbg_zero
);

    dec_t          dec;
    alu_e          alu_op;
    logic [DW-1:0] alu_a, alu_b, alu_y;

    cpu8_decode u_decode (
        .instr (mem_rdata),
        .dec   (dec)
    );

    cpu8_alu #(.W(DW)) u_alu (
        .op (alu_op),
        .a  (alu_a),
        .b  (alu_b),
        .y  (alu_y)
    );

    cpu8_seq #(.STACK_BASE(STACK_BASE)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec        (dec),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_wdata  (mem_wdata),
        .alu_op     (alu_op),
        .alu_a      (alu_a),
        .alu_b      (alu_b),
        .alu_y      (alu_y),
        .instr_done (instr_done),
        .dbg_pc     (dbg_pc),
        .dbg_sp     (dbg_sp),
        .dbg_acc    (dbg_acc),
        .dbg_b      (dbg_b),
        .dbg_c      (dbg_c),
        .dbg_zero   (dbg_zero)
    );

endmodule

// File: tb/cpu8_core_test.sv
`timescale 1ns/1ps
module cpu8_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic        instr_done;
    logic [15:0] dbg_pc, dbg_sp;
    logic [7:0]  dbg_acc, dbg_b, dbg_c;
    logic        dbg_zero;

    logic [7:0] mem [0:1023];
    int n_chk = 0;
    int n_bad = 0;
    int lp = 0;
    int clash = 0;

    always #2.5 clk = ~clk;

    cpu8_core #(.STACK_BASE(16'h0300)) uut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .instr_done(instr_done), .dbg_pc(dbg_pc), .dbg_sp(dbg_sp),
        .dbg_acc(dbg_acc), .dbg_b(dbg_b), .dbg_c(dbg_c), .dbg_zero(dbg_zero)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
        if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
    end

    always @(negedge clk) if (rst_n && mem_rd && mem_wr) clash++;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic hold_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        lp = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic org(input int a);
        lp = a;
    endtask

    task automatic emit(input logic [7:0] v);
        mem[lp] = v;
        lp++;
    endtask

    task automatic go();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            int guard = 0;
            do begin
                @(negedge clk);
                guard++;
            end while (!instr_done && guard < 200);
            if (!instr_done) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected instr_done");
                return;
            end
        end
    endtask

    task automatic t_reset();
        hold_reset();
        chk("R1", "pc", dbg_pc, 16'h0000);
        chk("R1", "sp", dbg_sp, 16'h0300);
        chk("R1", "acc", dbg_acc, 0);
        chk("R1", "b", dbg_b, 0);
        chk("R1", "c", dbg_c, 0);
        chk("R1", "zero", dbg_zero, 0);
        chk("R1", "done", instr_done, 0);
    endtask

    task automatic t_alu();
        hold_reset();
        emit(8'h08); emit(8'h05); emit(8'h09);
        emit(8'h08); emit(8'h03); emit(8'h0B);
        emit(8'h49);
        emit(8'h08); emit(8'h14); emit(8'h4C);
        emit(8'h0D); emit(8'h0E); emit(8'h4A);
        emit(8'h08); emit(8'h3C); emit(8'h09);
        emit(8'h08); emit(8'h0F); emit(8'h11); emit(8'h12);
        go();
        step(2); chk("R3", "STR to B", dbg_b, 8'h05);
        step(2); chk("R4", "ADD B", dbg_acc, 8'h08);
                 chk("R4", "zero after ADD", dbg_zero, 0);
        step(1); chk("R3", "STR to C", dbg_c, 8'h08);
        step(2); chk("R4", "SUB C", dbg_acc, 8'h0C);
        step(1); chk("R4", "MUL B", dbg_acc, 8'h3C);
        step(1); chk("R5", "DIV B", dbg_acc, 8'h0C);
        step(1); chk("R3", "LDR C", dbg_acc, 8'h08);
        step(2); chk("R3", "STR B again", dbg_b, 8'h3C);
        step(2); chk("R4", "AND B", dbg_acc, 8'h0C);
        step(1); chk("R4", "OR B", dbg_acc, 8'h3C);
    endtask

    task automatic t_edges();
        hold_reset();
        emit(8'h08); emit(8'h00); emit(8'h09); emit(8'h08); emit(8'h07); emit(8'h0E);
        emit(8'h08); emit(8'h10); emit(8'h49); emit(8'h4D);
        emit(8'h08); emit(8'h01); emit(8'h09); emit(8'h08); emit(8'h00); emit(8'h0C);
        emit(8'h08); emit(8'h08); emit(8'h09); emit(8'h08); emit(8'hFF); emit(8'h0F);
        emit(8'h08); emit(8'h03); emit(8'h49); emit(8'h08); emit(8'h81); emit(8'h50);
        emit(8'h4F);
        emit(8'h08); emit(8'h09); emit(8'h09); emit(8'h08); emit(8'h80); emit(8'h10);
        go();
        step(4); chk("R5", "divide by zero keeps acc", dbg_acc, 8'h07);
        step(3); chk("R4", "MUL truncates", dbg_acc, 8'h00);
                 chk("R4", "zero after MUL", dbg_zero, 1);
        step(4); chk("R4", "SUB wraps", dbg_acc, 8'hFF);
                 chk("R4", "zero after SUB", dbg_zero, 0);
        step(4); chk("R6", "SHL by 8", dbg_acc, 8'h00);
                 chk("R4", "zero after SHL", dbg_zero, 1);
        step(4); chk("R6", "SHR C by 3", dbg_acc, 8'h10);
        step(1); chk("R6", "SHL C by 3", dbg_acc, 8'h80);
        step(4); chk("R6", "SHR by 9", dbg_acc, 8'h00);
    endtask

    task automatic t_flags();
        hold_reset();
        emit(8'h08); emit(8'hFF); emit(8'h13);
        emit(8'h08); emit(8'h05);
        emit(8'h08); emit(8'h01); emit(8'h09); emit(8'h0B);
        emit(8'h15); emit(8'h14);
        go();
        step(2); chk("R4", "INC wraps", dbg_acc, 8'h00);
                 chk("R4", "zero after INC", dbg_zero, 1);
        step(1); chk("R7", "LDI keeps zero", dbg_zero, 1);
                 chk("R11", "LDI value", dbg_acc, 8'h05);
        step(3); chk("R4", "ADD result", dbg_acc, 8'h02);
        step(1); chk("R7", "CLR acc", dbg_acc, 8'h00);
                 chk("R7", "CLR keeps zero", dbg_zero, 0);
        step(1); chk("R7", "CLZ acc", dbg_acc, 8'h00);
                 chk("R7", "CLZ sets zero", dbg_zero, 1);
    endtask

    task automatic t_jumps();
        hold_reset();
        emit(8'h14); emit(8'h02); emit(8'h00); emit(8'h10);
        org(16'h10);
        emit(8'h13); emit(8'h02); emit(8'h00); emit(8'h20);
        emit(8'h03); emit(8'h00); emit(8'h30);
        org(16'h30);
        emit(8'h01); emit(8'h01); emit(8'h00);
        org(16'h100);
        emit(8'h14); emit(8'h03); emit(8'h02); emit(8'h00);
        go();
        step(2); chk("R8", "JZ taken", dbg_pc, 16'h0010);
        step(1); chk("R2", "PC step one", dbg_pc, 16'h0011);
        step(1); chk("R8", "JZ not taken", dbg_pc, 16'h0014);
        step(1); chk("R8", "JNZ taken", dbg_pc, 16'h0030);
        step(1); chk("R8", "JMP", dbg_pc, 16'h0100);
        step(2); chk("R8", "JNZ not taken", dbg_pc, 16'h0104);
    endtask

    task automatic t_stack();
        hold_reset();
        emit(8'h01); emit(8'h01); emit(8'hFE);
        org(16'h1FE);
        emit(8'h04); emit(8'h00); emit(8'h40);
        emit(8'h06); emit(8'h08); emit(8'h00); emit(8'h07);
        org(16'h40);
        emit(8'h08); emit(8'h77); emit(8'h05);
        go();
        step(2); chk("R9", "CALL target", dbg_pc, 16'h0040);
                 chk("R9", "CALL sp", dbg_sp, 16'h0302);
                 chk("R9", "return low byte", mem[10'h300], 8'h01);
                 chk("R9", "return high byte", mem[10'h301], 8'h02);
        step(2); chk("R10", "RET pc", dbg_pc, 16'h0201);
                 chk("R10", "RET sp", dbg_sp, 16'h0300);
        step(1); chk("R11", "PUSH sp", dbg_sp, 16'h0301);
                 chk("R11", "PUSH data", mem[10'h300], 8'h77);
        step(2); chk("R11", "POP acc", dbg_acc, 8'h77);
                 chk("R11", "POP sp", dbg_sp, 16'h0300);
                 chk("R7", "POP keeps zero", dbg_zero, 0);
    endtask

    task automatic t_misc();
        int cyc;
        hold_reset();
        emit(8'h08); emit(8'h42); emit(8'h3F); emit(8'h00); emit(8'h00);
        go();
        step(1);
        step(1); chk("R12", "undefined keeps acc", dbg_acc, 8'h42);
                 chk("R12", "undefined pc", dbg_pc, 16'h0003);
                 chk("R12", "undefined keeps sp", dbg_sp, 16'h0300);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!instr_done && cyc < 50);
        chk("R13", "NOP cycles", cyc, 3);
        @(negedge clk);
        chk("R13", "done one cycle", instr_done, 0);
        chk("R13", "no read/write clash", clash, 0);
    endtask

    initial begin
        t_reset();
        t_alu();
        t_edges();
        t_flags();
        t_jumps();
        t_stack();
        t_misc();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule